// File: doc/BRIEF.md
# Majority-Clocked Keystream Generator

This block produces a pseudo-random keystream, one bit at a time. It holds three linear feedback shift registers of 19, 22 and 23 bits. On each stepping cycle, one clocking bit from each register takes part in a majority vote. Only the registers whose clocking bit agrees with the vote advance. The keystream bit is the XOR of the most significant bit of each register. A downstream consumer XORs this bit with pixel or data bits.

A one-cycle `start` pulse captures a 64-bit session key and a 22-bit frame number and clears the registers. The block then performs three phases:
- It shifts the key into all three registers with regular clocking, least significant bit first.
- It shifts the frame number in the same way.
- It runs a warm-up of majority-clocked steps whose output is discarded.

After the warm-up it raises `ks_valid`. From then on, each cycle with `ks_en` high consumes the presented bit and advances the registers.

Top module: `keystream_gen`

## Requirements
- R1: After reset, `ks_valid` is 0 and `ks_bit` is 0, because all three registers are cleared.
- R2: `ks_bit` always equals r19[18] ^ r22[21] ^ r23[22].
- R2 (continued): Each register shifts toward its MSB. The new bit 0 is the XOR of these taps:
  - 19-bit register: bits 18, 17, 16 and 13 (x^19+x^5+x^2+x+1).
  - 22-bit register: bits 21 and 20 (x^22+x+1).
  - 23-bit register: bits 22, 21, 20 and 7 (x^23+x^15+x^2+x+1).
- R3: In warm-up and in keystream steps, the clocking bits are r19[8], r22[10] and r23[10]. The majority is 1 when two or more of them are 1. A register advances only when its clocking bit equals the majority; otherwise it holds.
- R4: The cycle after `start`, the block begins 64 regular-clocking cycles in which all three registers step. In cycle i, key bit i (LSB first) is XORed into each register's feedback.
- R5: The key phase is followed by 22 regular-clocking cycles that inject frame bits 0 to 21 in the same way.
- R6: The frame phase is followed by 100 majority-clocked cycles with the output discarded. `ks_valid` first reads 1 exactly 186 clock edges after the edge that sampled `start`.
- R7: A `start` pulse restarts the whole sequence at any time, including mid-load and mid-stream. `ks_valid` is 0 from the next edge until the new warm-up completes.
- R8: While `ks_valid` is 1 and `ks_en` is 0, no register changes and `ks_bit` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: capture key and frame, restart initialization |
| key | input | 64 | Session key, sampled with `start` |
| frame | input | 22 | Frame number, sampled with `start` |
| ks_en | input | 1 | Consume the current keystream bit and step |
| ks_bit | output | 1 | Current keystream bit |
| ks_valid | output | 1 | Keystream bit is usable |

## Verification
The hardest situation to reach is a restart that lands at an arbitrary point. This covers a `start` arriving mid-key-load or mid-stream, after the registers have taken an irregular path. The bench handles it in two ways. It pulses `start` during the key phase and again in the middle of a long random-enable stream. It then requires the following keystream to match a fresh model run for the new key and frame. Sparse and dense enable patterns exercise held registers over long stretches, where a step wrongly taken during a stall would shift the whole sequence.

// File: rtl/keystream_gen.sv
module keystream_gen #(
  parameter int KEY_W    = 64,
  parameter int FRAME_W  = 22,
  parameter int WARM_CYC = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [KEY_W-1:0]   key,
  input  logic [FRAME_W-1:0] frame,
  input  logic               ks_en,
  output logic               ks_bit,
  output logic               ks_valid
);
  localparam int CNT_W = $clog2(KEY_W + FRAME_W + WARM_CYC);

  typedef enum logic [2:0] {P_IDLE, P_KEY, P_FRAME, P_WARM, P_RUN} phase_t;

  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic [KEY_W-1:0]   key_q;
  logic [FRAME_W-1:0] frm_q;
  logic [18:0]        r1;
  logic [21:0]        r2;
  logic [22:0]        r3;

  wire c1  = r1[8];
  wire c2  = r2[10];
  wire c3  = r3[10];
  wire maj = (c1 & c2) | (c1 & c3) | (c2 & c3);

  wire regular = (phase == P_KEY) || (phase == P_FRAME);
  wire voting  = (phase == P_WARM) || ((phase == P_RUN) && ks_en);
  wire inbit   = (phase == P_KEY) ? key_q[0] : (phase == P_FRAME) ? frm_q[0] : 1'b0;

  wire s1 = regular | (voting & (c1 == maj));
  wire s2 = regular | (voting & (c2 == maj));
  wire s3 = regular | (voting & (c3 == maj));

  wire fb1 = r1[18] ^ r1[17] ^ r1[16] ^ r1[13];
  wire fb2 = r2[21] ^ r2[20];
  wire fb3 = r3[22] ^ r3[21] ^ r3[20] ^ r3[7];

  assign ks_bit   = r1[18] ^ r2[21] ^ r3[22];
  assign ks_valid = (phase == P_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE;
      cnt   <= '0;
      key_q <= '0;
      frm_q <= '0;
      r1    <= '0;
      r2    <= '0;
      r3    <= '0;
    end else if (start) begin
      phase <= P_KEY;
      cnt   <= '0;
      key_q <= key;
      frm_q <= frame;
      r1    <= '0;
      r2    <= '0;
      r3    <= '0;
    end else begin
      if (s1) r1 <= {r1[17:0], fb1 ^ inbit};
      if (s2) r2 <= {r2[20:0], fb2 ^ inbit};
      if (s3) r3 <= {r3[21:0], fb3 ^ inbit};
      unique case (phase)
        P_KEY: begin
          key_q <= key_q >> 1;
          if (cnt == CNT_W'(KEY_W - 1)) begin phase <= P_FRAME; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        P_FRAME: begin
          frm_q <= frm_q >> 1;
          if (cnt == CNT_W'(FRAME_W - 1)) begin phase <= P_WARM; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        P_WARM: begin
          if (cnt == CNT_W'(WARM_CYC - 1)) begin phase <= P_RUN; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_MAJ_TWO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    voting |-> ($countones({s1, s2, s3}) >= 2)) else $error("majority"); // R3
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && !ks_en && !start) |=> ($stable(r1) && $stable(r2) && $stable(r3) && $stable(ks_bit))) else $error("freeze"); // R8
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!ks_valid && phase == P_KEY)) else $error("restart"); // R7
  AST_KEY_TO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_KEY && cnt == CNT_W'(KEY_W - 1) && !start) |=> (phase == P_FRAME)) else $error("key"); // R4
  AST_VALID_AFTER_WARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ks_valid) |-> ($past(phase) == P_WARM)) else $error("warm"); // R6
endmodule

// File: tb/keystream_gen_bench.sv
`timescale 1ns/1ps
module keystream_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] key = '0;
  logic [21:0] frame = '0;
  logic        ks_en = 1'b0;
  logic        ks_bit, ks_valid;

  always #5 clk = ~clk;

  keystream_gen u_keystream_gen (.clk(clk), .rst_n(rst_n), .start(start), .key(key),
    .frame(frame), .ks_en(ks_en), .ks_bit(ks_bit), .ks_valid(ks_valid));

  int checks = 0;
  int errors = 0;
  logic [18:0] m1;
  logic [21:0] m2;
  logic [22:0] m3;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit mout();
    return m1[18] ^ m2[21] ^ m3[22];
  endfunction

  task automatic mstep(input bit regular, input bit inb);
    bit maj, a, b, c;
    a = m1[8]; b = m2[10]; c = m3[10];
    maj = (a & b) | (a & c) | (b & c);
    if (regular || a == maj) m1 = {m1[17:0], m1[18]^m1[17]^m1[16]^m1[13]^inb};
    if (regular || b == maj) m2 = {m2[20:0], m2[21]^m2[20]^inb};
    if (regular || c == maj) m3 = {m3[21:0], m3[22]^m3[21]^m3[20]^m3[7]^inb};
  endtask

  task automatic minit(input logic [63:0] k, input logic [21:0] f);
    m1 = '0; m2 = '0; m3 = '0;
    for (int i = 0; i < 64; i++) mstep(1'b1, k[i]);
    for (int i = 0; i < 22; i++) mstep(1'b1, f[i]);
    for (int i = 0; i < 100; i++) mstep(1'b0, 1'b0);
  endtask

  task automatic launch(input logic [63:0] k, input logic [21:0] f);
    ks_en = 1'b0; key = k; frame = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(ks_valid == 1'b0, "R7 valid low after start", 32'(ks_valid), 0);
    minit(k, f);
    repeat (185) @(negedge clk);
    chk(ks_valid == 1'b0, "R6 valid before warm-up end", 32'(ks_valid), 0);
    @(negedge clk);
    chk(ks_valid == 1'b1, "R6 valid after 186 edges", 32'(ks_valid), 1);
    chk(ks_bit == mout(), "R4 R5 first bit after load", 32'(ks_bit), 32'(mout()));
  endtask

  task automatic stream(input int n, input int pct);
    bit prev_en = 1'b1;
    bit prev_bit = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk(ks_bit == mout(), "R2 R3 keystream bit", 32'(ks_bit), 32'(mout()));
      if (!prev_en) chk(ks_bit == prev_bit, "R8 bit held while disabled", 32'(ks_bit), 32'(prev_bit));
      ks_en = (($urandom % 100) < pct);
      if (ks_en) mstep(1'b0, 1'b0);
      prev_en = ks_en; prev_bit = ks_bit;
      @(negedge clk);
    end
    ks_en = 1'b0;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog R6 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(ks_valid == 1'b0, "R1 valid in reset", 32'(ks_valid), 0);
    chk(ks_bit == 1'b0, "R1 bit in reset", 32'(ks_bit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ks_valid == 1'b0, "R1 valid after reset", 32'(ks_valid), 0);
    chk(ks_bit == 1'b0, "R1 bit after reset", 32'(ks_bit), 0);

    launch(64'h0123_4567_89AB_CDEF, 22'h134);
    stream(300, 100);
    launch('1, '1);
    stream(200, 50);
    launch(64'h0000_0000_0000_0001, 22'h0);
    stream(200, 80);
    launch('0, 22'h20_0000);
    stream(200, 10);

    key = {$urandom, $urandom}; frame = 22'($urandom); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    chk(ks_valid == 1'b0, "R7 still loading", 32'(ks_valid), 0);
    launch({$urandom, $urandom}, 22'($urandom));
    stream(250, 60);

    for (int r = 0; r < 3; r++) begin
      launch({$urandom, $urandom}, 22'($urandom));
      stream(150, 30 + 30 * r);
    end

    launch({$urandom, $urandom}, 22'($urandom));
    stream(120, 70);
    launch({$urandom, $urandom}, 22'($urandom));
    stream(300, 40);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule